// File: doc/BRIEF.md
# Wavetable Voice Pitch Generator

This block is a single voice of a multi-voice wavetable sound generator. It holds a 32-entry table of signed 8-bit samples and a 5-bit play pointer into it. A 12-bit period counter advances the play pointer at a rate set by the pitch period. The counter steps once for each single-cycle tick strobe.

On every clock the block scales the table entry under the pointer by a 4-bit volume and registers the result as a signed sample. A low voice enable forces that sample to zero.

Pitch periods below nine freeze the voice. A test control splits the counter into an 8-bit low part and a 4-bit high part that count down on their own. Pitch, volume, enable and the test controls come from register decode outside the block. A read port lets the surrounding logic see any table entry.

Top module: `wt_voice`

## Requirements
- R1: While `rst_ni` is low, the play pointer, the period counter, every table entry and the sample output are all cleared to zero.
- R2: When `wr_en_i` is high at a clock edge, the table entry at `wr_addr_i` (0..31) takes `wr_data_i`. `rd_data_o` always shows the entry at `rd_addr_i`.
- R3: In normal mode (`split_i` low), each tick with `pitch_i` of 9 or more does one of two things. If the counter is zero, the pointer increments and the counter is loaded with `pitch_i`. Otherwise the counter decrements by one. From reset, the first tick therefore advances the pointer, and each further step takes `pitch_i`+1 ticks.
- R4: The play pointer is 5 bits wide and wraps from 31 to 0.
- R5: When `pitch_i` is below 9, ticks change neither the counter nor the pointer.
- R6: In split mode (`split_i` high), counter bits 7:0 and bits 11:8 each decrement on every tick and wrap within their own width. A step (pointer increment plus reload from `pitch_i`) happens when bits 11:8 are zero at the tick.
- R7: `sample_o` is an 11-bit signed value, registered. It equals floor(entry × volume / 16), with the entry read as two's complement and the volume as unsigned. It reflects the pointer, volume and enable one cycle after they change, so it stays within -120..119.
- R8: When `enable_i` is low, `sample_o` is zero on the next cycle.
- R9: `ptr_clr_i` high sets the pointer to zero on the next edge. This overrides a pointer step and leaves the counter untouched.
- R10: Without a tick or a clear, the pointer holds its value.
- R11: While the voice is halted (R5), `sample_o` still follows the current entry, the volume and the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle counter step strobe |
| pitch_i | input | 12 | Pitch period |
| volume_i | input | 4 | Unsigned volume |
| enable_i | input | 1 | Voice enable |
| split_i | input | 1 | Split-counter test mode |
| ptr_clr_i | input | 1 | Synchronous play pointer clear |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 5 | Table write address |
| wr_data_i | input | 8 | Table write data |
| rd_addr_i | input | 5 | Table read address |
| rd_data_o | output | 8 | Table entry at rd_addr_i |
| ptr_o | output | 5 | Current play pointer |
| sample_o | output | 11 | Scaled signed sample |

## Verification
The pointer rate is exercised in several ways:
- Periods of 9 and 20 in normal mode, with tick counts just below and at each step boundary. These separate the pitch+1 period from off-by-one variants.
- A run of 311 ticks, which shows the wrap at 32.
- Periods of 8 and 0, which must freeze the voice.
- One pitch value applied in both normal and split mode. The two modes must step after different tick counts, so that comparison tells whether the split borrow comes from the high nibble.
- The sample scaling uses the most negative and most positive entries, and -1 (which checks floor rounding), at two volumes.
- A pointer clear taken mid-period checks that the counter keeps its phase.

// File: rtl/wt_voice_pkg.sv
package wt_voice_pkg;
  localparam int unsigned PERIOD_W   = 12;
  localparam int unsigned SPLIT_LO_W = 8;
  localparam int unsigned PTR_W      = 5;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned VOL_W      = 4;
  localparam int unsigned OUT_W      = 11;
  localparam int unsigned MIN_PERIOD = 9;
  localparam int unsigned DEPTH      = 1 << PTR_W;
endpackage

// File: rtl/wt_voice_phase.sv
module wt_voice_phase
  import wt_voice_pkg::*;
#(
  parameter int unsigned PW    = PERIOD_W,
  parameter int unsigned LO_W  = SPLIT_LO_W,
  parameter int unsigned AW    = PTR_W,
  parameter int unsigned MINP  = MIN_PERIOD
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          split_i,
  input  logic          ptr_clr_i,
  input  logic [PW-1:0] pitch_i,
  output logic [AW-1:0] ptr_o
);
  localparam int unsigned HI_W = PW - LO_W;

  logic [PW-1:0]   cnt_q, cnt_dec;
  logic [LO_W-1:0] lo_dec;
  logic [HI_W-1:0] hi_dec;
  logic [AW-1:0]   ptr_q;
  logic            run, step, borrow;

  assign run  = (pitch_i >= PW'(MINP));
  assign step = tick_i && run;

  always_comb begin
    lo_dec = cnt_q[LO_W-1:0] - LO_W'(1);
    hi_dec = cnt_q[PW-1:LO_W] - HI_W'(1);
    if (split_i) begin
      cnt_dec = {hi_dec, lo_dec};
      // split borrow: high part wraps, making the counter grow
      borrow  = (cnt_q[PW-1:LO_W] == '0);
    end else begin
      cnt_dec = cnt_q - PW'(1);
      borrow  = (cnt_q == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= borrow ? pitch_i : cnt_dec;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ptr_clr_i) begin
      ptr_q <= '0;
    end else if (step && borrow) begin
      ptr_q <= ptr_q + AW'(1);
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/wt_voice_table.sv
module wt_voice_table
  import wt_voice_pkg::*;
#(
  parameter int unsigned AW = PTR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [AW-1:0] play_addr_i,
  output logic [DW-1:0] play_data_o
);
  localparam int unsigned N = 1 << AW;

  logic [DW-1:0] mem_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o   = mem_q[rd_addr_i];
  assign play_data_o = mem_q[play_addr_i];
endmodule

// File: rtl/wt_voice_scale.sv
module wt_voice_scale
  import wt_voice_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned VW = VOL_W,
  parameter int unsigned OW = OUT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DW-1:0]        entry_i,
  input  logic [VW-1:0]        volume_i,
  input  logic                 enable_i,
  output logic signed [OW-1:0] sample_o
);
  localparam int unsigned PROD_W = DW + VW + 1;

  logic signed [PROD_W-1:0] prod, shifted;
  logic signed [OW-1:0]     sample_d, sample_q;

  always_comb begin
    prod     = PROD_W'($signed(entry_i)) * PROD_W'($signed({1'b0, volume_i}));
    shifted  = prod >>> VW;
    sample_d = enable_i ? OW'(shifted) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_q <= '0;
    else         sample_q <= sample_d;
  end

  assign sample_o = sample_q;
endmodule

// File: rtl/wt_voice.sv
module wt_voice
  import wt_voice_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic [PERIOD_W-1:0]     pitch_i,
  input  logic [VOL_W-1:0]        volume_i,
  input  logic                    enable_i,
  input  logic                    split_i,
  input  logic                    ptr_clr_i,
  input  logic                    wr_en_i,
  input  logic [PTR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [PTR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic [PTR_W-1:0]        ptr_o,
  output logic signed [OUT_W-1:0] sample_o
);
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] entry;

  wt_voice_phase u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .split_i   (split_i),
    .ptr_clr_i (ptr_clr_i),
    .pitch_i   (pitch_i),
    .ptr_o     (ptr)
  );

  wt_voice_table u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .play_addr_i (ptr),
    .play_data_o (entry)
  );

  wt_voice_scale u_scale (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .entry_i  (entry),
    .volume_i (volume_i),
    .enable_i (enable_i),
    .sample_o (sample_o)
  );

  assign ptr_o = ptr;
endmodule

// File: rtl/wt_voice_chk.sv
module wt_voice_chk
  import wt_voice_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic [PERIOD_W-1:0]     pitch_i,
  input logic                    enable_i,
  input logic                    ptr_clr_i,
  input logic [PTR_W-1:0]        ptr_o,
  input logic signed [OUT_W-1:0] sample_o
);
  localparam int SMAX = ((2 ** (DATA_W - 1) - 1) * (2 ** VOL_W - 1)) >>> VOL_W;
  localparam int SMIN = (-(2 ** (DATA_W - 1)) * (2 ** VOL_W - 1)) >>> VOL_W;

  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ptr_clr_i && pitch_i < PERIOD_W'(MIN_PERIOD)) |=> $stable(ptr_o)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ptr_clr_i) |=> $stable(ptr_o)); // R10
  AST_PTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_clr_i |=> (ptr_o == '0)); // R9
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ptr_clr_i |=> (ptr_o == $past(ptr_o) || ptr_o == $past(ptr_o) + PTR_W'(1))); // R4
  AST_DISABLED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (sample_o == '0)); // R8
  AST_SAMPLE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sample_o) <= SMAX && int'(sample_o) >= SMIN)); // R7
endmodule

bind wt_voice wt_voice_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .pitch_i   (pitch_i),
  .enable_i  (enable_i),
  .ptr_clr_i (ptr_clr_i),
  .ptr_o     (ptr_o),
  .sample_o  (sample_o)
);

// File: tb/wt_voice_tb.sv
module wt_voice_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  // pitch, split, ticks after reset, expected pointer
  localparam int VEC [NVEC][4] = '{
    '{9, 0, 1, 1},      '{9, 0, 10, 1},     '{9, 0, 11, 2},
    '{9, 0, 21, 3},     '{8, 0, 5, 0},      '{0, 0, 3, 0},
    '{20, 0, 22, 2},    '{20, 0, 43, 3},    '{9, 0, 311, 0},
    '{'h123, 0, 3, 1},  '{'h123, 1, 3, 2},  '{'h123, 1, 5, 3},
    '{'h312, 1, 5, 2}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic [11:0] pitch_i = '0;
  logic [3:0] volume_i = '0;
  logic enable_i = 1'b0;
  logic split_i = 1'b0;
  logic ptr_clr_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [4:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [4:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic [4:0] ptr_o;
  logic signed [10:0] sample_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wt_voice u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .pitch_i(pitch_i),
    .volume_i(volume_i), .enable_i(enable_i), .split_i(split_i),
    .ptr_clr_i(ptr_clr_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .ptr_o(ptr_o), .sample_o(sample_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en_i = 1'b1; wr_addr_i = 5'(a); wr_data_i = 8'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  function automatic int scaled(input int e8, input int vol);
    int e;
    e = (e8 >= 128) ? e8 - 256 : e8;
    return (e * vol) >>> 4;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 ptr", int'(ptr_o), 0);
    check("R1 sample", int'(sample_o), 0);
    check("R1 table", int'(rd_data_o), 0);

    // R3 R4 R5 R6 pointer rate vectors
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      pitch_i = 12'(VEC[i][0]);
      split_i = VEC[i][1][0];
      ticks(VEC[i][2]);
      check($sformatf("R3/R4/R5/R6 vec %0d", i), int'(ptr_o), VEC[i][3]);
    end
    split_i = 1'b0;

    // R2 table write and read
    do_reset();
    pitch_i = 12'd0;
    wr(0, 'h80); wr(1, 'h7F); wr(2, 'hFF); wr(31, 'h5A);
    rd_addr_i = 5'd31;
    #1 check("R2 read 31", int'(rd_data_o), 'h5A);
    rd_addr_i = 5'd1;
    #1 check("R2 read 1", int'(rd_data_o), 'h7F);

    // R7 scaling and latency
    enable_i = 1'b1; volume_i = 4'd15;
    @(negedge clk); @(negedge clk);
    check("R7 min entry vol15", int'(sample_o), scaled('h80, 15));
    volume_i = 4'd1;
    @(negedge clk);
    check("R7 min entry vol1", int'(sample_o), scaled('h80, 1));
    volume_i = 4'd15;
    @(negedge clk);
    pitch_i = 12'd9;
    ticks(1);
    check("R3 first tick step", int'(ptr_o), 1);
    check("R7 latency old value", int'(sample_o), scaled('h80, 15));
    @(negedge clk);
    check("R7 max entry vol15", int'(sample_o), scaled('h7F, 15));
    ticks(10);
    @(negedge clk);
    check("R3 period pitch+1", int'(ptr_o), 2);
    check("R7 floor of -1", int'(sample_o), -1);

    // R8 enable low
    enable_i = 1'b0;
    @(negedge clk);
    check("R8 disabled zero", int'(sample_o), 0);
    enable_i = 1'b1;

    // R5 R11 halted but output live
    pitch_i = 12'd5;
    volume_i = 4'd0;
    ticks(5);
    @(negedge clk);
    check("R5 halted ptr", int'(ptr_o), 2);
    check("R11 halted vol0", int'(sample_o), 0);
    volume_i = 4'd15;
    @(negedge clk);
    check("R11 halted vol15", int'(sample_o), -1);

    // R10 idle hold
    pitch_i = 12'd9;
    repeat (15) @(negedge clk);
    check("R10 idle ptr", int'(ptr_o), 2);

    // R9 clear keeps counter phase (counter at 9 after last step)
    ptr_clr_i = 1'b1;
    @(negedge clk);
    ptr_clr_i = 1'b0;
    check("R9 cleared", int'(ptr_o), 0);
    ticks(1);
    check("R9 counter kept", int'(ptr_o), 0);
    ticks(9);
    check("R9 step after phase", int'(ptr_o), 1);

    // R1 reset clears table
    do_reset();
    rd_addr_i = 5'd31;
    #1 check("R1 table cleared", int'(rd_data_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule